// File: doc/BRIEF.md
# Segmented Flash Access Rights Checker

This block sits in front of an on-chip flash array and decides, in the same cycle, whether each read transaction may proceed. The flash address range is cut into a power-of-two number of equal segments. Each segment has two rights bits: an execute-only bit and a supervisor-only bit. Every transaction carries an address, a kind (instruction fetch or data read) and a privilege level (privileged or user). The checker looks up the segment's bits and either passes the flash data through with a grant, or returns zero data with an error response.

The rights are held in two write-once registers, one bit per segment in each. The execute-only mask is selected by `prog_sel`=0 and the supervisor-only mask by `prog_sel`=1. The first write to a register loads it and locks it. Any later write to that register is dropped and raises a one-cycle violation pulse. After reset both registers are clear and unlocked, so every segment starts unsecured. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `flash_rights_chk`

## Requirements
- R1: The segment index is the top log2(SEG_COUNT) bits of `req_addr`, which equals the address divided by the segment size. Only that segment's bit in each mask governs the decision.
- R2: The decision is combinational in the cycle the request is presented. With `req_valid`=1, exactly one of `rsp_grant`/`rsp_err` is 1. With `req_valid`=0, both are 0 and `rsp_rdata` is 0.
- R3: In a segment whose execute-only bit is 1, a fetch (`req_fetch`=1) is not refused on that account. A data read (`req_fetch`=0) is refused.
- R4: In a segment whose supervisor-only bit is 1, a privileged access (`req_priv`=1) is not refused on that account. A user access (`req_priv`=0) is refused.
- R5: In a segment with both bits set, only a privileged fetch is granted.
- R6: In a segment with both bits clear, all four combinations of kind and privilege are granted.
- R7: A granted access returns `flash_rdata` on `rsp_rdata`. A refused access returns all zeros and asserts `rsp_err`.
- R8: After reset both masks are zero and unlocked. The first write to a register (selected by `prog_sel`) loads `prog_data` into it and locks it. Later writes to a locked register leave its contents unchanged.
- R9: A write to a locked register drives `prog_viol` high for exactly the cycle after that write. A write to an unlocked register does not.
- R10: The two registers lock independently. Locking one does not block the first write to the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Rights register write strobe |
| prog_sel | input | 1 | Register select: 0 execute-only mask, 1 supervisor-only mask |
| prog_data | input | SEG_COUNT | Mask value, bit i for segment i |
| prog_viol | output | 1 | Pulse: write to an already locked register |
| req_valid | input | 1 | Transaction present |
| req_addr | input | ADDR_W | Flash byte address |
| req_fetch | input | 1 | 1 instruction fetch, 0 data read |
| req_priv | input | 1 | 1 privileged, 0 user |
| flash_rdata | input | DATA_W | Data from the flash array |
| rsp_grant | output | 1 | Access allowed |
| rsp_err | output | 1 | Access refused, bus error |
| rsp_rdata | output | DATA_W | Returned data, zero when refused |

## Verification
The bench builds the block with ADDR_W=10, SEG_COUNT=8 and DATA_W=16, so 128-byte segments. This makes it cheap to sweep every address against all four kind/privilege combinations, and also with the request idle. Each sweep is repeated for several mask states: unprogrammed, execute-only programmed, both programmed, and after rejected rewrites. That covers every segment boundary and every bit combination. The expected grant is computed from the address quotient and the masks the bench believes were accepted.

// File: rtl/flash_rights_pkg.sv
package flash_rights_pkg;
  localparam int unsigned NUM_RIGHT_REGS = 2;
  localparam logic        SEL_EXEC_ONLY  = 1'b0;
  localparam logic        SEL_SUPV_ONLY  = 1'b1;

  typedef struct packed {
    logic exec_only;
    logic supv_only;
  } seg_rights_t;
endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/flash_wo_reg.sv
module flash_wo_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q,
  output logic         viol
);
  logic [W-1:0] val_q, val_d;
  logic         lock_q, lock_d;
  logic         viol_q, viol_d;
  logic         load_en;

  always_comb begin
    load_en = wr_en && !lock_q;
    val_d   = val_q;
    lock_d  = lock_q;
    if (load_en) begin
      val_d  = wr_data;
      lock_d = 1'b1;
    end
    viol_d = wr_en && lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      lock_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      if (load_en) val_q <= val_d;
      lock_q <= lock_d;
      viol_q <= viol_d;
    end
  end

  assign q    = val_q;
  assign viol = viol_q;

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R8
  frozen_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(val_q));
  // R8
  first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock_q) |=> (lock_q && val_q == $past(wr_data)));
  // R9
  viol_on_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_q) |=> viol);
  // R9
  no_viol_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !lock_q) |=> !viol);
endmodule

// File: rtl/flash_seg_lookup.sv
module flash_seg_lookup
  import flash_rights_pkg::*;
#(
  parameter int unsigned SEG_COUNT = 8,
  localparam int unsigned IDX_W    = $clog2(SEG_COUNT)
) (
  input  logic [IDX_W-1:0]     seg_idx,
  input  logic [SEG_COUNT-1:0] xo_mask,
  input  logic [SEG_COUNT-1:0] sv_mask,
  output seg_rights_t          rights
);
  always_comb begin
    rights.exec_only = xo_mask[seg_idx];
    rights.supv_only = sv_mask[seg_idx];
  end
endmodule

// File: rtl/flash_rights_eval.sv
module flash_rights_eval
  import flash_rights_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              fetch,
  input  logic              priv,
  input  seg_rights_t       rights,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              grant,
  output logic              err,
  output logic [DATA_W-1:0] rdata_out
);
  logic xo_block, sv_block, deny;

  always_comb begin
    xo_block  = rights.exec_only && !fetch;
    sv_block  = rights.supv_only && !priv;
    deny      = xo_block || sv_block;
    grant     = valid && !deny;
    err       = valid && deny;
    rdata_out = grant ? rdata_in : '0;
  end

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (grant != err));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!grant && !err && rdata_out == '0));
  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rdata_out == '0));
  // R7
  grant_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (rdata_out == rdata_in));
endmodule

// File: rtl/flash_rights_chk.sv
module flash_rights_chk
  import flash_rights_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SEG_COUNT = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_we,
  input  logic                 prog_sel,
  input  logic [SEG_COUNT-1:0] prog_data,
  output logic                 prog_viol,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_fetch,
  input  logic                 req_priv,
  input  logic [DATA_W-1:0]    flash_rdata,
  output logic                 rsp_grant,
  output logic                 rsp_err,
  output logic [DATA_W-1:0]    rsp_rdata
);
  localparam int unsigned IDX_W = $clog2(SEG_COUNT);

  logic                      rst_s;
  logic [SEG_COUNT-1:0]      mask_q [NUM_RIGHT_REGS];
  logic [NUM_RIGHT_REGS-1:0] viol_v;
  logic [IDX_W-1:0]          seg_idx;
  seg_rights_t               seg_rights;

  flash_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  for (genvar g = 0; g < NUM_RIGHT_REGS; g++) begin : g_rreg
    logic sel_hit;
    assign sel_hit = prog_we && (prog_sel == 1'(g));
    flash_wo_reg #(.W(SEG_COUNT)) u_reg (
      .clk     (clk),
      .rst_n   (rst_s),
      .wr_en   (sel_hit),
      .wr_data (prog_data),
      .q       (mask_q[g]),
      .viol    (viol_v[g])
    );
  end

  assign prog_viol = |viol_v;
  assign seg_idx   = req_addr[ADDR_W-1 -: IDX_W];

  flash_seg_lookup #(.SEG_COUNT(SEG_COUNT)) u_look (
    .seg_idx (seg_idx),
    .xo_mask (mask_q[SEL_EXEC_ONLY]),
    .sv_mask (mask_q[SEL_SUPV_ONLY]),
    .rights  (seg_rights)
  );

  flash_rights_eval #(.DATA_W(DATA_W)) u_eval (
    .clk       (clk),
    .rst_n     (rst_s),
    .valid     (req_valid),
    .fetch     (req_fetch),
    .priv      (req_priv),
    .rights    (seg_rights),
    .rdata_in  (flash_rdata),
    .grant     (rsp_grant),
    .err       (rsp_err),
    .rdata_out (rsp_rdata)
  );

  // R3
  xo_data_deny_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && !req_fetch && mask_q[SEL_EXEC_ONLY][seg_idx]) |-> rsp_err);
  // R4
  sv_user_deny_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && !req_priv && mask_q[SEL_SUPV_ONLY][seg_idx]) |-> rsp_err);
  // R5
  both_priv_fetch_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && req_fetch && req_priv) |-> rsp_grant);
  // R6
  open_seg_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && !mask_q[SEL_EXEC_ONLY][seg_idx] && !mask_q[SEL_SUPV_ONLY][seg_idx])
      |-> rsp_grant);
  // R9
  viol_single_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $countones(viol_v) <= 1);
endmodule

// File: tb/flash_rights_chk_tb.sv
module flash_rights_chk_tb;
  localparam int unsigned AW = 10;
  localparam int unsigned SC = 8;
  localparam int unsigned DW = 16;
  localparam int unsigned SHIFT = AW - 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_we, prog_sel;
  logic [SC-1:0] prog_data;
  logic          prog_viol;
  logic          req_valid, req_fetch, req_priv;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] flash_rdata;
  logic          rsp_grant, rsp_err;
  logic [DW-1:0] rsp_rdata;

  int total = 0;
  int bad   = 0;
  logic [SC-1:0] exp_xo, exp_sv;

  always #10 clk = ~clk;

  flash_rights_chk #(.ADDR_W(AW), .SEG_COUNT(SC), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_sel(prog_sel), .prog_data(prog_data),
    .prog_viol(prog_viol),
    .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch),
    .req_priv(req_priv), .flash_rdata(flash_rdata),
    .rsp_grant(rsp_grant), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1 R3 R4 R5 R6 R7: sweep every address and all kind/privilege pairs
  task automatic sweep(input string tag);
    for (int a = 0; a < (1 << AW); a++) begin
      int seg;
      seg = a >> SHIFT;
      for (int k = 0; k < 4; k++) begin
        bit f, p, ok;
        logic [DW-1:0] d;
        f  = k[0];
        p  = k[1];
        ok = !(exp_xo[seg] && !f) && !(exp_sv[seg] && !p);
        d  = DW'(a * 37 + k + 16'h5A00);
        req_valid = 1'b1; req_addr = AW'(a); req_fetch = f; req_priv = p;
        flash_rdata = d;
        #1;
        chk(rsp_grant == ok && rsp_err == !ok, {tag, " R1 R3 R4 R5 R6 grant"},
            {rsp_grant, rsp_err}, {ok, !ok});
        chk(rsp_rdata == (ok ? d : '0), {tag, " R7 data"}, rsp_rdata, ok ? d : 0);
      end
      req_valid = 1'b0;
      #1;
      chk(!rsp_grant && !rsp_err && rsp_rdata == '0, {tag, " R2 idle"},
          {rsp_grant, rsp_err, rsp_rdata}, 0);
    end
  endtask

  task automatic prog(input logic sel, input logic [SC-1:0] val, input bit expect_viol,
                      input string tag);
    @(negedge clk);
    prog_we = 1'b1; prog_sel = sel; prog_data = val;
    @(negedge clk);
    prog_we = 1'b0;
    #1;
    chk(prog_viol == expect_viol, {tag, " R9 viol pulse"}, prog_viol, expect_viol);
    @(negedge clk);
    #1;
    chk(prog_viol == 1'b0, {tag, " R9 viol one cycle"}, prog_viol, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_sel = 1'b0; prog_data = '0;
    req_valid = 1'b0; req_addr = '0; req_fetch = 1'b0; req_priv = 1'b0;
    flash_rdata = '0;
    exp_xo = '0; exp_sv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!rsp_grant && !rsp_err && !prog_viol && rsp_rdata == '0, "reset R2 R8",
        {rsp_grant, rsp_err, prog_viol}, 0);

    // R8 R6: unprogrammed means open everywhere
    sweep("open");

    // R8 R3: first execute-only write is accepted
    exp_xo = 8'b1010_0110;
    prog(1'b0, exp_xo, 1'b0, "xo first");
    sweep("xo");

    // R10: supervisor register still takes its first write
    exp_sv = 8'b0011_1100;
    prog(1'b1, exp_sv, 1'b0, "sv first R10");
    sweep("xo+sv R5");

    // R8 R9: rewrites are dropped and flagged
    prog(1'b0, 8'hFF, 1'b1, "xo rewrite R8");
    prog(1'b1, 8'h00, 1'b1, "sv rewrite R8");
    sweep("locked R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule